// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block sits between a simple valid/ready host port and an external pseudo-static RAM. The RAM has an asynchronous SRAM-style interface and refreshes itself internally. Each host request is one 16-bit word at a 20-bit word address. A request is either a read or a write and carries a two-bit lane mask. The controller turns the request into a strobe sequence on chip enable, write enable, output enable and two active-low byte enables. Every strobe width is a whole number of system clocks. Each width is derived from a nanosecond parameter and the clock period, and is rounded up.

Requests that arrive back to back keep chip enable low and only change the address between accesses. Because of the internal refresh, chip enable must not stay low for a long time. The block counts how many cycles chip enable has been low. It raises chip enable for a full access time whenever a further access would pass a programmable limit, and then carries on with the pending work. When no request is waiting, chip enable goes high for at least its minimum high time. The address stays on the pins during that time.

Reads return the selected lanes on a single-cycle response strobe. Lanes the host did not select read as zero. The read data is taken on the last cycle in which output enable is low.

Top module: `psram_ctrl`

## Requirements
- R1: After a synchronous reset, chip enable, write enable and output enable are high, both byte enables are high, the data drive enable and rsp_valid are low, and req_ready is high.
- R2: A read at any 20-bit address returns, on rsp_rdata, the data last written to that address in the lanes it selects.
- R3: Mask bit 0 selects data bits 7:0 and drives mem_be_n[0]; mask bit 1 selects bits 15:8 and drives mem_be_n[1]. A write changes only the selected lanes. On a read, unselected lanes of rsp_rdata are zero.
- R4: A write whose mask is 00 leaves the memory contents unchanged.
- R5: A read holds output enable low for ACC_CYC cycles per access (7 at the defaults). rsp_valid pulses in the cycle after the last of those cycles, so the cycle before it always has output enable low.
- R6: During a write, write enable is low for exactly WP_CYC cycles from the start of the access (5 at the defaults). It is then high for at least WEH_CYC cycles (2) before the next write pulse.
- R7: Chip enable is never low for more than LIMIT_CYC consecutive cycles. When a further access would pass that limit, chip enable is held high for at least GAP_FORCE_CYC cycles (7) before the next access. Otherwise back-to-back requests keep chip enable low.
- R8: The data bus drive enable is high exactly while chip enable and write enable are both low, extended by DH_CYC cycles (0 at the defaults).
- R9: Output enable stays high in every cycle in which write enable is low.
- R10: While chip enable is high, mem_addr keeps the address of the previous access.
- R11: Every accepted read produces exactly one response, and responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle's edge when also valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Address to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data returned by the RAM |

## Verification
A phase counter or state register that is off by one shows up first as a strobe of the wrong width. A write pulse of 4 or 6 cycles, or an output-enable run that is not a multiple of the access length, is flagged at the end of that same access. A wrong chip-enable run counter either lets a burst run past 28 low cycles or ends it early. The bench checks this at every rising edge of chip enable and again against the longest run seen. A wrong lane mask or a lost write has no effect on the strobes. It shows up only when the address is read back later, which the random traffic over a small pool of addresses does within a few operations.

// File: rtl/psram_pkg.sv
// Shared types and timing helpers for the pseudo-static RAM controller.
// Assumes all timing parameters are non-negative nanosecond values.
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_GAP  = 2'd2
    } psram_state_t;

    // Rounds a nanosecond figure up to whole clock cycles.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_phase_ctr.sv
// Phase counter shared by the access and gap states.
// Clears to zero on restart and otherwise counts up, saturating at all ones.
module psram_phase_ctr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);

    // Count cycles since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/psram_ce_guard.sv
// Watches chip enable and flags when one more access would push the
// low period past LIMIT_CYC cycles. Assumes LIMIT_CYC >= ACC_CYC.
module psram_ce_guard #(
    parameter int unsigned LIMIT_CYC = 800,
    parameter int unsigned ACC_CYC   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic near_limit
);

    localparam int unsigned CW = $clog2(LIMIT_CYC + 1);
    localparam logic [CW-1:0] TRIP = CW'(LIMIT_CYC - ACC_CYC);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT_CYC);

    logic [CW-1:0] low_run;

    // Number of earlier consecutive cycles with chip enable low.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_n)
            low_run <= '0;
        else if (low_run != TOP)
            low_run <= low_run + 1'b1;
    end

    assign near_limit = !ce_n && (low_run >= TRIP);

endmodule

// File: rtl/psram_ctrl.sv
// Host-side controller for a hidden-refresh pseudo-static RAM.
// One request is one word access lasting ACC_CYC clocks. Back-to-back
// requests keep chip enable low. A guard forces a chip-enable-high gap
// of GAP_FORCE_CYC clocks before the low period would reach LIMIT_CYC.
// Assumes DW is a multiple of 8 and T_CE_MAX_NS covers at least one access.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned AW          = 20,
    parameter int unsigned DW          = 16,
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned T_RC_NS     = 70,
    parameter int unsigned T_AA_NS     = 70,
    parameter int unsigned T_WP_NS     = 50,
    parameter int unsigned T_WEH_NS    = 20,
    parameter int unsigned T_DH_NS     = 0,
    parameter int unsigned T_CEH_NS    = 10,
    parameter int unsigned T_AHC_NS    = 10,
    parameter int unsigned T_CE_MAX_NS = 8000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_we,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [DW/8-1:0]     req_be,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DW/8-1:0]     mem_be_n,
    output logic [DW-1:0]       mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_dq_in
);

    localparam int unsigned LANES         = DW / 8;
    localparam int unsigned RC_CYC        = ns2cyc(T_RC_NS, CLK_NS);
    localparam int unsigned AA_CYC        = ns2cyc(T_AA_NS, CLK_NS);
    localparam int unsigned WP_CYC        = ns2cyc(T_WP_NS, CLK_NS);
    localparam int unsigned WEH_CYC       = ns2cyc(T_WEH_NS, CLK_NS);
    localparam int unsigned DH_CYC        = ns2cyc(T_DH_NS, CLK_NS);
    localparam int unsigned ACC_CYC       = imax(imax(RC_CYC, AA_CYC),
                                                 imax(WP_CYC + WEH_CYC, WP_CYC + DH_CYC));
    localparam int unsigned GAP_MIN_CYC   = imax(imax(ns2cyc(T_CEH_NS, CLK_NS),
                                                      ns2cyc(T_AHC_NS, CLK_NS)), 1);
    localparam int unsigned GAP_FORCE_CYC = imax(RC_CYC, GAP_MIN_CYC);
    localparam int unsigned LIMIT_CYC     = T_CE_MAX_NS / CLK_NS;
    localparam int unsigned PH_W          = $clog2(imax(ACC_CYC, GAP_FORCE_CYC) + 1);

    localparam logic [PH_W-1:0] PH_ACC_LAST  = PH_W'(ACC_CYC - 1);
    localparam logic [PH_W-1:0] PH_WE_END    = PH_W'(WP_CYC);
    localparam logic [PH_W-1:0] PH_DRV_END   = PH_W'(WP_CYC + DH_CYC);
    localparam logic [PH_W-1:0] PH_GAP_SHORT = PH_W'(GAP_MIN_CYC - 1);
    localparam logic [PH_W-1:0] PH_GAP_LONG  = PH_W'(GAP_FORCE_CYC - 1);

    psram_state_t     st_q;
    logic [PH_W-1:0]  phase;
    logic             near_limit;
    logic             force_q;
    logic             acc_last;
    logic             gap_done;
    logic             accept;
    logic             restart;
    logic             in_acc;
    logic [AW-1:0]    addr_q;
    logic             we_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    rd_masked;
    logic             rsp_valid_q;
    logic [DW-1:0]    rdata_q;

    psram_phase_ctr #(.W(PH_W)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt     (phase)
    );

    psram_ce_guard #(.LIMIT_CYC(LIMIT_CYC), .ACC_CYC(ACC_CYC)) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (mem_ce_n),
        .near_limit (near_limit)
    );

    assign in_acc    = (st_q == ST_ACC);
    assign acc_last  = in_acc && (phase == PH_ACC_LAST);
    assign gap_done  = (st_q == ST_GAP) && (phase == (force_q ? PH_GAP_LONG : PH_GAP_SHORT));
    assign req_ready = (st_q == ST_IDLE) || (acc_last && !near_limit);
    assign accept    = req_valid && req_ready;
    assign restart   = accept || acc_last || gap_done;

    // Sequencing between idle, access and chip-enable-high gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) st_q <= ST_ACC;
                ST_ACC:  if (acc_last && !accept) st_q <= ST_GAP;
                ST_GAP:  if (gap_done) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Choose the gap length when an access closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_q <= 1'b0;
        else if (acc_last)
            force_q <= near_limit;
    end

    // Capture the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Zero the lanes the request did not select.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_masked[8*l +: 8] = be_q[l] ? mem_dq_in[8*l +: 8] : 8'h00;
    end

    // Sample read data on the final cycle of a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= acc_last && !we_q;
            if (acc_last && !we_q)
                rdata_q <= rd_masked;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_ce_n   = !in_acc;
    assign mem_oe_n   = !(in_acc && !we_q);
    assign mem_we_n   = !(in_acc && we_q && (phase < PH_WE_END));
    assign mem_dq_oe  = in_acc && we_q && (phase < PH_DRV_END);
    assign mem_be_n   = in_acc ? ~be_q : '1;

endmodule

// File: rtl/psram_ctrl_chk.sv
// Property checker for psram_ctrl, attached with bind below.
// Tracks the chip-enable low run and write pulse width with its own counters.
module psram_ctrl_chk #(
    parameter int unsigned AW        = 20,
    parameter int unsigned LIMIT_CYC = 800,
    parameter int unsigned WP_CYC    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr,
    input logic          rsp_valid
);

    localparam int unsigned CW = $clog2(LIMIT_CYC + 2);

    logic [CW-1:0] ce_run;
    logic [CW-1:0] we_run;

    // Count consecutive low cycles of chip enable and write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run <= '0;
            we_run <= '0;
        end else begin
            ce_run <= mem_ce_n ? '0 : ((ce_run != '1) ? ce_run + 1'b1 : ce_run);
            we_run <= mem_we_n ? '0 : ((we_run != '1) ? we_run + 1'b1 : we_run);
        end
    end

    p_ce_run_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (ce_run < CW'(LIMIT_CYC)));

    p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == CW'(WP_CYC)));

    p_drive_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    p_oe_off_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n && $past(mem_ce_n)) |-> $stable(mem_addr));

    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .AW        (AW),
    .LIMIT_CYC (LIMIT_CYC),
    .WP_CYC    (WP_CYC)
) i_psram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/test_psram_ctrl.sv
// Self-checking bench: pin-level RAM model, expected-data model, timing monitor.
module test_psram_ctrl;

    localparam int ACC   = 7;   // access length in cycles at the defaults
    localparam int WP    = 5;   // write pulse cycles
    localparam int WEH   = 2;   // write-enable-high cycles between writes
    localparam int LIMIT = 30;  // 300 ns limit at a 10 ns clock
    localparam int FORCE = 7;   // forced gap cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] model_mem [logic [19:0]];
    logic [15:0] exp_mem   [logic [19:0]];
    logic [15:0] rsp_exp_q [$];
    string       rsp_tag_q [$];

    always #5 clk = ~clk;

    psram_ctrl #(.T_CE_MAX_NS(300)) i_psram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [15:0] m [logic [19:0]], input logic [19:0] a);
        return m.exists(a) ? m[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] sel);
        logic [15:0] r = old;
        if (sel[0]) r[7:0]  = d[7:0];
        if (sel[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    // Pin-level monitor and RAM model, sampled away from the active edge.
    bit          prev_ce_n = 1, prev_we_n = 1, prev_oe_n = 1, prev_wr = 0;
    int          ce_low = 0, ce_high = 0, last_low = 0, max_run = 0;
    int          oe_low = 0, we_low = 0, we_high = 0;
    bit          wrote = 0, strobe_bad = 0, addr_bad = 0, have_low = 0;
    logic [19:0] wr_addr, last_low_addr;
    logic [15:0] wr_data;
    logic [1:0]  wr_be_n;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit wr_act = !mem_ce_n && !mem_we_n;
            automatic logic [15:0] w;
            // R8 / R9: drive enable tracks the write strobe, output enable stays off
            if ((mem_dq_oe != wr_act) || (wr_act && !mem_oe_n)) strobe_bad = 1;
            if (wr_act) begin
                wr_addr = mem_addr; wr_data = mem_dq_out; wr_be_n = mem_be_n;
            end
            if (prev_wr && !wr_act) begin
                w = model_mem.exists(wr_addr) ? model_mem[wr_addr] : 16'h0;
                model_mem[wr_addr] = merge(w, wr_data, ~wr_be_n);
                chk(!strobe_bad, "R8/R9 strobe/drive enable", {31'd0, strobe_bad}, 0);
                strobe_bad = 0;
            end
            // R6: write pulse width and high time between pulses
            if (!mem_we_n) begin
                if (prev_we_n && wrote) chk(we_high >= WEH, "R6 we high gap", we_high, WEH);
                we_low++;
            end else begin
                if (!prev_we_n) begin
                    chk(we_low == WP, "R6 we low width", we_low, WP);
                    we_low = 0; wrote = 1; we_high = 0;
                end
                if (!mem_ce_n && wrote) we_high++;
            end
            // R5: output enable low in whole accesses
            if (!mem_oe_n) oe_low++;
            else if (!prev_oe_n) begin
                chk(oe_low > 0 && oe_low % ACC == 0, "R5 oe low run", oe_low, ACC);
                oe_low = 0;
            end
            // R7 / R10: chip enable low runs, forced gaps, address hold
            if (!mem_ce_n) begin
                if (prev_ce_n) begin
                    if (last_low > LIMIT - ACC)
                        chk(ce_high >= FORCE, "R7 forced gap", ce_high, FORCE);
                    if (have_low) chk(!addr_bad, "R10 address hold", {31'd0, addr_bad}, 0);
                    addr_bad = 0; ce_low = 0;
                end
                ce_low++;
                last_low_addr = mem_addr; have_low = 1;
            end else begin
                if (!prev_ce_n) begin
                    chk(ce_low <= LIMIT, "R7 ce low run", ce_low, LIMIT);
                    last_low = ce_low;
                    if (ce_low > max_run) max_run = ce_low;
                    ce_high = 0; wrote = 0;
                end
                ce_high++;
                if (have_low && mem_addr != last_low_addr) addr_bad = 1;
            end
            // R5 / R11 / R2 / R3: responses
            if (rsp_valid) begin
                chk(!prev_oe_n, "R5 rsp latency", {31'd0, prev_oe_n}, 0);
                if (rsp_exp_q.size() == 0) chk(0, "R11 unexpected response", rsp_rdata, 0);
                else begin
                    automatic logic [15:0] e = rsp_exp_q.pop_front();
                    automatic string t = rsp_tag_q.pop_front();
                    chk(rsp_rdata == e, t, rsp_rdata, e);
                end
            end
            // Read data returned by the model, filler on unselected lanes
            begin
                automatic logic [15:0] m = word_of(model_mem, mem_addr);
                automatic logic [15:0] d = 16'hA5A5;
                if (!mem_ce_n && !mem_oe_n) begin
                    if (!mem_be_n[0]) d[7:0]  = m[7:0];
                    if (!mem_be_n[1]) d[15:8] = m[15:8];
                end
                mem_dq_in = d;
            end
            prev_ce_n = mem_ce_n; prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_wr = wr_act;
        end
    end

    task automatic send(input bit we, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, input string tag);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (we) exp_mem[a] = merge(word_of(exp_mem, a), d, be);
        else begin
            rsp_exp_q.push_back(merge(16'h0000, word_of(exp_mem, a), be));
            rsp_tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] pool [12];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(mem_be_n == 2'b11 && !mem_dq_oe && !rsp_valid && req_ready, "R1 idle outputs",
            {mem_be_n, mem_dq_oe, rsp_valid, req_ready}, 5'b11001);

        // R2: full word write and read at both address extremes
        send(1, 20'hFFFFF, 16'hC3E1, 2'b11, "R2");
        send(1, 20'h00000, 16'h1B2D, 2'b11, "R2");
        idle(3);
        send(0, 20'hFFFFF, 0, 2'b11, "R2 read top address");
        send(0, 20'h00000, 0, 2'b11, "R2 read address zero");
        idle(3);

        // R3: lane masks on writes and reads
        send(1, 20'h12345, 16'hBEEF, 2'b11, "R3");
        send(1, 20'h12345, 16'h7734, 2'b01, "R3");
        send(1, 20'h12345, 16'h5A00, 2'b10, "R3");
        send(0, 20'h12345, 0, 2'b10, "R3 read high lane");
        send(0, 20'h12345, 0, 2'b01, "R3 read low lane");
        idle(2);

        // R4: empty mask write leaves the word alone
        send(1, 20'h12345, 16'hFFFF, 2'b00, "R4");
        idle(1);
        send(0, 20'h12345, 0, 2'b11, "R4 empty mask write ignored");
        idle(2);

        // R7: a long burst is split by a forced gap
        for (int i = 0; i < 9; i++) send(0, 20'(i * 3), 0, 2'b11, "R7 burst read");
        idle(12);

        // Random mix over a small address pool
        for (int i = 0; i < 12; i++) pool[i] = 20'($urandom);
        pool[0] = 20'h00000; pool[1] = 20'hFFFFF;
        for (int i = 0; i < 400; i++) begin
            automatic bit we = $urandom_range(0, 1) == 1;
            send(we, pool[$urandom_range(0, 11)], 16'($urandom), 2'($urandom),
                 "R2/R3 random read");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 4));
        end
        idle(40);

        chk(max_run == 4 * ACC, "R7 longest low run", max_run, 4 * ACC);
        chk(rsp_exp_q.size() == 0, "R11 all reads answered", rsp_exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule